// File: doc/BRIEF.md
# Flash Array Program/Erase Engine

This block holds a byte-addressed flash storage image in on-chip registers and carries out the two operations that change it: programming a single byte and erasing an aligned region. A command front end hands it one request at a time as an operation code, an address, a data byte and the current state of the write-enable latch. The engine answers with a busy indication and two sticky error flags. A separate read port lets the front end fetch any byte at any time.

A program operation is a single-cycle read-modify-write. In the default mode it stores the bitwise AND of the old byte and the new data, so it can only clear bits. When the write-ones capability is configured, the new byte replaces the old one outright. An erase is done by a sequential walker that writes the erased value 0xFF to one byte per clock across the aligned region. At reset the same walker sweeps the whole array, so the image starts erased without any initial values on storage.

The array geometry is set by parameters: sector size, sector count, and the two smaller erase granules. The two smaller granules default to a scaled-down 16 and 64 bytes; a full-size part would use 4096 and 32768. Three capability bits say whether the small erase and the half-block erase are supported and whether write-ones programming applies. All region sizes are powers of two.

Top module: `flash_pe_engine`

## Requirements
- R1: After `rst_n` rises, `busy` stays high for exactly TOTAL+1 clock cycles, counted from the first rising edge after release, where TOTAL = SECTOR_BYTES*SECTOR_COUNT. After that, every byte of the array reads 0xFF and both error flags read 0.
- R2: A program request (`req_kind` = 0) accepted with `wr_en` high and write-ones mode off leaves the addressed byte equal to its old value ANDed with `req_data`. No other byte changes and `busy` stays low.
- R3: A program request accepted with `wr_en` low leaves the array unchanged and sets `err_prot` on the next cycle.
- R4: A small erase (`req_kind` = 1) accepted with `wr_en` high writes 0xFF to the SUB_BYTES region that contains `req_addr`, aligned down. `busy` is high for exactly SUB_BYTES cycles and no byte outside the region changes.
- R5: A half-block erase (`req_kind` = 2) covers the aligned HALF_BYTES region, and a sector erase (`req_kind` = 3) covers the aligned SECTOR_BYTES region. Each holds `busy` high for as many cycles as the region has bytes.
- R6: A bulk erase (`req_kind` = 4) with `wr_en` high sets every byte of the array to 0xFF and holds `busy` high for TOTAL cycles.
- R7: Any erase accepted with `wr_en` low changes no byte, leaves `busy` low and sets `err_prot`.
- R8: A small or half-block erase requested on a configuration that lacks that capability sets `err_cap`, whatever the state of `wr_en`. The erase is still performed when `wr_en` is high.
- R9: Both error flags stay set until an `err_clr` strobe. A flag set in the same cycle as a clear stays set.
- R10: A request presented while `busy` is high is ignored: it changes no byte and sets no flag.
- R11: `rd_data` presents the byte stored at the `rd_addr` value sampled at the previous rising edge.
- R12: The reserved `req_kind` codes 5, 6 and 7 change nothing, start no walk and set no flag.
- R13: With write-ones mode configured, an accepted program with `wr_en` high stores `req_data` exactly, which may set bits back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe; accepted when `busy` is low |
| req_kind | input | 3 | 0 program, 1 small erase, 2 half-block erase, 3 sector erase, 4 bulk erase, 5-7 reserved |
| req_addr | input | AW | Program address or erase start offset |
| req_data | input | 8 | Program data byte |
| wr_en | input | 1 | Write-enable latch state from the front end |
| err_clr | input | 1 | Clears both error flags |
| rd_addr | input | AW | Read port address |
| busy | output | 1 | Walker active; requests are ignored |
| err_prot | output | 1 | Sticky: write or erase attempted while write-protected |
| err_cap | output | 1 | Sticky: erase granule not supported |
| rd_data | output | 8 | Registered read data |

## Verification
A walker pointer or end bound that is off by one shows up as a `busy` pulse one cycle too long or too short. It also shows up as a stray 0xFF byte just outside the erased region, or as one left unerased. Both are seen on the very next read sweep. A wrong alignment mask erases the wrong neighbourhood, which the full-array comparison against the bench's own image exposes. A missing AND, or a wrong write-enable gate, shows as a mismatching byte or flag one cycle after the request.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

  typedef enum logic [2:0] {
    OP_PROGRAM  = 3'd0,
    OP_ER_SMALL = 3'd1,
    OP_ER_HALF  = 3'd2,
    OP_ER_SECT  = 3'd3,
    OP_ER_BULK  = 3'd4
  } op_kind_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

endpackage

// File: rtl/fpe_rst_sync.sv
module fpe_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;

endmodule

// File: rtl/fpe_region_calc.sv
module fpe_region_calc #(
  parameter int AW           = 9,
  parameter int SUB_BYTES    = 16,
  parameter int HALF_BYTES   = 64,
  parameter int SECTOR_BYTES = 128,
  parameter int TOTAL_BYTES  = 512,
  parameter bit CAP_SUB      = 1'b1,
  parameter bit CAP_HALF     = 1'b0
) (
  input  logic [2:0]    kind,
  input  logic [AW-1:0] addr,
  output logic          is_prog,
  output logic          is_erase,
  output logic          cap_miss,
  output logic [AW-1:0] first,
  output logic [AW-1:0] last
);
  import fpe_pkg::*;

  localparam logic [AW-1:0] SUB_M  = AW'(SUB_BYTES - 1);
  localparam logic [AW-1:0] HALF_M = AW'(HALF_BYTES - 1);
  localparam logic [AW-1:0] SECT_M = AW'(SECTOR_BYTES - 1);
  localparam logic [AW-1:0] TOP    = AW'(TOTAL_BYTES - 1);

  op_kind_e      op;
  logic [AW-1:0] mask;

  always_comb begin
    op       = op_kind_e'(kind);
    is_prog  = 1'b0;
    is_erase = 1'b0;
    cap_miss = 1'b0;
    mask     = '0;
    first    = addr;
    last     = addr;
    case (op)
      OP_PROGRAM: is_prog = 1'b1;
      OP_ER_SMALL: begin
        is_erase = 1'b1;
        cap_miss = ~CAP_SUB;
        mask     = SUB_M;
      end
      OP_ER_HALF: begin
        is_erase = 1'b1;
        cap_miss = ~CAP_HALF;
        mask     = HALF_M;
      end
      OP_ER_SECT: begin
        is_erase = 1'b1;
        mask     = SECT_M;
      end
      OP_ER_BULK: begin
        is_erase = 1'b1;
      end
      default: ;
    endcase
    if (is_erase) begin
      if (op == OP_ER_BULK) begin
        first = '0;
        last  = TOP;
      end else begin
        first = addr & ~mask;
        last  = (addr & ~mask) | mask;
      end
    end
  end

endmodule

// File: rtl/fpe_walker.sv
module fpe_walker #(
  parameter int AW          = 9,
  parameter int TOTAL_BYTES = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] first,
  input  logic [AW-1:0] last,
  output logic          busy,
  output logic [AW-1:0] ptr
);

  localparam logic [AW-1:0] TOP = AW'(TOTAL_BYTES - 1);

  logic          busy_q, busy_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [AW-1:0] end_q, end_d;
  logic          step_en;

  assign step_en = start | busy_q;

  always_comb begin
    busy_d = busy_q;
    ptr_d  = ptr_q;
    end_d  = end_q;
    if (start) begin
      busy_d = 1'b1;
      ptr_d  = first;
      end_d  = last;
    end else if (busy_q) begin
      if (ptr_q == end_q) begin
        busy_d = 1'b0;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b1;
      ptr_q  <= '0;
      end_q  <= TOP;
    end else if (step_en) begin
      busy_q <= busy_d;
      ptr_q  <= ptr_d;
      end_q  <= end_d;
    end
  end

  assign busy = busy_q;
  assign ptr  = ptr_q;

endmodule

// File: rtl/fpe_array.sv
module fpe_array #(
  parameter int AW    = 9,
  parameter int DEPTH = 512
) (
  input  logic          clk,
  input  logic          we,
  input  logic          and_mode,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];
  logic [7:0] merged;

  always_comb begin
    merged = and_mode ? (mem[waddr] & wdata) : wdata;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= merged;
    end
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/flash_pe_engine.sv
module flash_pe_engine #(
  parameter int SECTOR_BYTES = 128,
  parameter int SECTOR_COUNT = 4,
  parameter int SUB_BYTES    = 16,
  parameter int HALF_BYTES   = 64,
  parameter bit CAP_SUB      = 1'b1,
  parameter bit CAP_HALF     = 1'b0,
  parameter bit CAP_WR1      = 1'b0,
  localparam int TOTAL       = SECTOR_BYTES * SECTOR_COUNT,
  localparam int AW          = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  input  logic          wr_en,
  input  logic          err_clr,
  input  logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic          err_prot,
  output logic          err_cap,
  output logic [7:0]    rd_data
);
  import fpe_pkg::*;

  logic          srst_n;
  logic          accept;
  logic          is_prog, is_erase, cap_miss;
  logic [AW-1:0] reg_first, reg_last;
  logic          walk_start;
  logic          walk_busy;
  logic [AW-1:0] walk_ptr;
  logic          prog_write;
  logic          prot_hit, cap_hit;
  logic          prot_q, prot_d, cap_q, cap_d;
  logic          err_en;
  logic          mem_we, mem_and;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;

  fpe_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  fpe_region_calc #(
    .AW           (AW),
    .SUB_BYTES    (SUB_BYTES),
    .HALF_BYTES   (HALF_BYTES),
    .SECTOR_BYTES (SECTOR_BYTES),
    .TOTAL_BYTES  (TOTAL),
    .CAP_SUB      (CAP_SUB),
    .CAP_HALF     (CAP_HALF)
  ) u_region (
    .kind     (req_kind),
    .addr     (req_addr),
    .is_prog  (is_prog),
    .is_erase (is_erase),
    .cap_miss (cap_miss),
    .first    (reg_first),
    .last     (reg_last)
  );

  assign accept     = req_valid & ~walk_busy;
  assign walk_start = accept & is_erase & wr_en;
  assign prog_write = accept & is_prog & wr_en;
  assign prot_hit   = accept & (is_prog | is_erase) & ~wr_en;
  assign cap_hit    = accept & cap_miss;

  fpe_walker #(
    .AW          (AW),
    .TOTAL_BYTES (TOTAL)
  ) u_walker (
    .clk   (clk),
    .rst_n (srst_n),
    .start (walk_start),
    .first (reg_first),
    .last  (reg_last),
    .busy  (walk_busy),
    .ptr   (walk_ptr)
  );

  always_comb begin
    if (walk_busy) begin
      mem_we    = 1'b1;
      mem_and   = 1'b0;
      mem_waddr = walk_ptr;
      mem_wdata = ERASED_BYTE;
    end else begin
      mem_we    = prog_write;
      mem_and   = ~CAP_WR1;
      mem_waddr = req_addr;
      mem_wdata = req_data;
    end
  end

  fpe_array #(
    .AW    (AW),
    .DEPTH (TOTAL)
  ) u_array (
    .clk      (clk),
    .we       (mem_we),
    .and_mode (mem_and),
    .waddr    (mem_waddr),
    .wdata    (mem_wdata),
    .raddr    (rd_addr),
    .rdata    (rd_data)
  );

  assign err_en = err_clr | prot_hit | cap_hit;

  always_comb begin
    prot_d = (prot_q & ~err_clr) | prot_hit;
    cap_d  = (cap_q & ~err_clr) | cap_hit;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      prot_q <= 1'b0;
      cap_q  <= 1'b0;
    end else if (err_en) begin
      prot_q <= prot_d;
      cap_q  <= cap_d;
    end
  end

  assign busy     = walk_busy;
  assign err_prot = prot_q;
  assign err_cap  = cap_q;

endmodule

// File: rtl/fpe_checker.sv
module fpe_checker #(
  parameter bit CAP_SUB  = 1'b1,
  parameter bit CAP_HALF = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_kind,
  input logic       wr_en,
  input logic       err_clr,
  input logic       busy,
  input logic       err_prot,
  input logic       err_cap
);

  logic acc, k_prog, k_erase;
  assign acc     = req_valid && !busy;
  assign k_prog  = (req_kind == 3'd0);
  assign k_erase = (req_kind >= 3'd1) && (req_kind <= 3'd4);

  AST_PROG_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    acc && k_prog && !wr_en |=> err_prot); // R3

  AST_ERASE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    acc && k_erase && wr_en |=> busy); // R4

  AST_ERASE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    acc && k_erase && !wr_en |=> !busy && err_prot); // R7

  AST_CAP_MISSING: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ((req_kind == 3'd2 && !CAP_HALF) || (req_kind == 3'd1 && !CAP_SUB)) |=> err_cap); // R8

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_prot && !err_clr) |=> err_prot); // R9

  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !err_prot && !err_cap |=> !err_prot && !err_cap); // R10

  AST_RESERVED_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (req_kind > 3'd4) |=> !busy); // R12

endmodule

bind flash_pe_engine fpe_checker #(
  .CAP_SUB  (CAP_SUB),
  .CAP_HALF (CAP_HALF)
) u_fpe_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .wr_en     (wr_en),
  .err_clr   (err_clr),
  .busy      (busy),
  .err_prot  (err_prot),
  .err_cap   (err_cap)
);

// File: tb/flash_pe_engine_tb_top.sv
`timescale 1ns/1ps
module flash_pe_engine_tb_top;

  localparam int TOTAL = 512;
  localparam int AW    = 9;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [2:0]    req_kind;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_data;
  logic          wr_en;
  logic          err_clr;
  logic [AW-1:0] rd_addr;
  logic          busy, err_prot, err_cap;
  logic [7:0]    rd_data;
  logic          busy_w, prot_w, cap_w;
  logic [7:0]    rd_data_w;

  int vectors;
  int fails;
  int cycles;
  logic [7:0] img [TOTAL];

  flash_pe_engine dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_data(req_data), .wr_en(wr_en), .err_clr(err_clr),
    .rd_addr(rd_addr), .busy(busy), .err_prot(err_prot), .err_cap(err_cap),
    .rd_data(rd_data)
  );

  flash_pe_engine #(.CAP_HALF(1'b1), .CAP_WR1(1'b1)) dut_w1_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_data(req_data), .wr_en(wr_en), .err_clr(err_clr),
    .rd_addr(rd_addr), .busy(busy_w), .err_prot(prot_w), .err_cap(cap_w),
    .rd_data(rd_data_w)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] k, input int a, input logic [7:0] d, input logic we);
    @(negedge clk);
    req_valid = 1'b1;
    req_kind  = k;
    req_addr  = AW'(a);
    req_data  = d;
    wr_en     = we;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic rd(input int a, output logic [7:0] v, output logic [7:0] vw);
    @(negedge clk);
    rd_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    v  = rd_data;
    vw = rd_data_w;
  endtask

  task automatic sweep(input string tag);
    logic [7:0] v, vw;
    for (int a = 0; a < TOTAL; a++) begin
      rd(a, v, vw);
      chk($sformatf("%s R11 byte %0h", tag, a), v, img[a]);
    end
  endtask

  task automatic erase_model(input int first, input int len);
    for (int a = first; a < first + len; a++) img[a] = 8'hFF;
  endtask

  task automatic clear_errs();
    @(negedge clk);
    err_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  initial begin
    int n;
    logic [7:0] v, vw;
    logic [7:0] d1, d2;
    vectors = 0;
    fails = 0;
    rst_n = 1'b0;
    req_valid = 1'b0; req_kind = '0; req_addr = '0; req_data = '0;
    wr_en = 1'b0; err_clr = 1'b0; rd_addr = '0;
    for (int a = 0; a < TOTAL; a++) img[a] = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset sweep length and erased image
    n = 0;
    forever begin
      @(posedge clk);
      @(negedge clk);
      if (busy) n++;
      else break;
    end
    chk("R1 reset busy cycles", n, TOTAL + 1);
    chk("R1 err_prot after reset", err_prot, 0);
    chk("R1 err_cap after reset", err_cap, 0);
    sweep("R1");

    // R2 / R13: two program passes, AND versus replace
    for (int i = 0; i < 32; i++) begin
      d1 = 8'(i * 37 + 11);
      issue(3'd0, i * 16 + 3, d1, 1'b1);
      chk("R2 busy low after program", busy, 0);
      img[i * 16 + 3] = img[i * 16 + 3] & d1;
    end
    for (int i = 0; i < 32; i++) begin
      d1 = 8'(i * 37 + 11);
      d2 = 8'(i * 91 + 5);
      issue(3'd0, i * 16 + 3, d2, 1'b1);
      img[i * 16 + 3] = img[i * 16 + 3] & d2;
      rd(i * 16 + 3, v, vw);
      chk("R2 AND program", v, d1 & d2);
      chk("R13 write-ones program", vw, d2);
    end
    chk("R2 no error", err_prot, 0);

    // R3 / R9: protected program, sticky flag, clear
    issue(3'd0, 100, 8'h00, 1'b0);
    chk("R3 err_prot set", err_prot, 1);
    repeat (3) @(negedge clk);
    chk("R9 err_prot sticky", err_prot, 1);
    rd(100, v, vw);
    chk("R3 byte unchanged", v, img[100]);
    clear_errs();
    chk("R9 err_prot cleared", err_prot, 0);

    // R9: set and clear in the same cycle, set wins
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd0; req_addr = AW'(7); req_data = 8'h00;
    wr_en = 1'b0; err_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; err_clr = 1'b0;
    chk("R9 set beats clear", err_prot, 1);
    clear_errs();

    // R4: small erase aligned down
    issue(3'd1, 'h1A3, 8'h00, 1'b1);
    count_busy(n);
    chk("R4 small erase busy", n, 16);
    erase_model('h1A0, 16);
    chk("R4 no cap error", err_cap, 0);

    // R5 / R8: half erase unsupported on dut_i, still performed
    issue(3'd2, 'h0C5, 8'h00, 1'b1);
    chk("R8 err_cap set", err_cap, 1);
    chk("R8 cap flag clear on capable instance", cap_w, 0);
    count_busy(n);
    chk("R5 half erase busy", n, 64);
    erase_model('h0C0, 64);
    clear_errs();
    chk("R9 err_cap cleared", err_cap, 0);

    // R5 / R10: sector erase with a request injected while busy
    issue(3'd3, 'h150, 8'h00, 1'b1);
    repeat (5) @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd0; req_addr = AW'('h10); req_data = 8'h00; wr_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    count_busy(n);
    chk("R5 sector erase busy", n, 128 - 6);
    chk("R10 no flag while busy", err_prot, 0);
    erase_model('h100, 128);

    // R7: erase while protected
    issue(3'd1, 'h013, 8'h00, 1'b0);
    chk("R7 no walk", busy, 0);
    chk("R7 err_prot", err_prot, 1);
    clear_errs();

    // R12: reserved code
    for (int k = 5; k < 8; k++) begin
      issue(3'(k), 'h023, 8'h00, 1'b1);
      chk("R12 no walk", busy, 0);
      chk("R12 no prot flag", err_prot, 0);
      chk("R12 no cap flag", err_cap, 0);
    end

    sweep("R4 R5 R7 R10 R12");

    // R6: bulk erase
    issue(3'd4, 'h0AB, 8'h00, 1'b1);
    count_busy(n);
    chk("R6 bulk busy", n, TOTAL);
    erase_model(0, TOTAL);
    sweep("R6");

    summary();
  end

endmodule